// File: doc/BRIEF.md
# Predicated Widening Vector Multiplier

This unit takes two 128-bit vector operands, picks either every even-numbered or every odd-numbered narrow integer element from both, and multiplies each pair into a product twice as wide as its sources. The products are packed into a 128-bit result vector. Source elements are 8, 16 or 32 bits wide, so the result holds 8, 4 or 2 lanes of 16-, 32- or 64-bit products. Products are kept at full width and never saturated.

A 16-bit predicate mask has one bit per destination byte. It merges the new products into the previous destination value one byte at a time. It sits in an execution pipeline next to the vector register file: the issue logic presents the operands, the old destination, the operation fields and a valid strobe. One clock later the unit returns the merged result with its own valid strobe. The size code 11 does not name a widening form. For that code the unit flags an illegal operation and returns the old destination unchanged.

Top module: `wmul_top`

## Requirements
- R1: `elemSize` 00, 01 and 10 select 8-, 16- and 32-bit source elements, which give 8, 4 and 2 result lanes of 16, 32 and 64 bits. Packing is little-endian: element k of width w bits occupies bits [w*k +: w] in the sources and in the result.
- R2: With `useTop` = 0, result lane i uses source element 2*i of both operands. With `useTop` = 1, it uses source element 2*i+1 of both operands.
- R3: With `isUnsigned` = 0, both source elements are sign-extended before multiplying, and the full double-width two's-complement product is kept. For example, -128 times -128 at 8 bits gives 16'h4000.
- R4: With `isUnsigned` = 1, both source elements are zero-extended and the full product is kept. For example, 32'hFFFFFFFF squared gives 64'hFFFFFFFE00000001.
- R5: Destination byte b takes byte b of the packed products when `byteMask[b]` is 1. Otherwise it keeps byte b of `oldDst`. A zero mask returns `oldDst` unchanged.
- R6: An accepted operation with `elemSize` = 11 sets `illegalOp` to 1 together with `outValid`, and returns `result` equal to `oldDst` whatever the mask is.
- R7: `outValid` and the merged `result` appear on the first rising clock edge after a cycle in which `inValid` is 1. Back-to-back operations produce back-to-back results.
- R8: In a cycle after one with `inValid` = 0, `outValid` and `illegalOp` are 0 and `result` keeps its previous value.
- R9: While `rstN` is 0, `outValid`, `illegalOp` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Operation presented this cycle |
| opA | input | 128 | First source vector |
| opB | input | 128 | Second source vector |
| oldDst | input | 128 | Previous destination value used for merging |
| elemSize | input | 2 | Source element size code (00/01/10, 11 illegal) |
| isUnsigned | input | 1 | 1 = zero-extend sources, 0 = sign-extend |
| useTop | input | 1 | 1 = odd source elements, 0 = even source elements |
| byteMask | input | 16 | Per-destination-byte write enable |
| outValid | output | 1 | Result valid |
| result | output | 128 | Merged result vector |
| illegalOp | output | 1 | Accepted operation had an illegal size code |

## Verification
The assertions check the timing rules on every clock:
- each accepted operation is followed by a valid result, and idle cycles leave the result frozen with both flags low;
- an illegal size code raises the flag and passes the old destination through;
- an all-zero mask passes the old destination through.

The arithmetic itself can only be shown by the bench's scenarios. These cover lane selection, sign versus zero extension, product width and byte-level merging. A behavioural model is compared with the outputs on every cycle, across directed extreme operands and a long random mix of sizes, variants, masks and idle gaps.

// File: rtl/wmul_pkg.sv
package wmul_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } elemSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic illegal;
  } ctrlStrobe_t;

  localparam int NUM_SIZES = 3;
  localparam int MIN_ELEM_BITS = 8;

endpackage

// File: rtl/wmul_lane.sv
module wmul_lane #(
  parameter int ESZ = 8
) (
  input  logic [2*ESZ-1:0] pairA,
  input  logic [2*ESZ-1:0] pairB,
  input  logic             useTop,
  input  logic             signExt,
  output logic [2*ESZ-1:0] prod
);

  logic [ESZ-1:0]   selA, selB;
  logic [2*ESZ-1:0] extA, extB;

  assign selA = useTop ? pairA[2*ESZ-1:ESZ] : pairA[ESZ-1:0];
  assign selB = useTop ? pairB[2*ESZ-1:ESZ] : pairB[ESZ-1:0];

  assign extA = {{ESZ{signExt & selA[ESZ-1]}}, selA};
  assign extB = {{ESZ{signExt & selB[ESZ-1]}}, selB};

  // modular product of the extended values is exact at double width
  assign prod = extA * extB;

endmodule

// File: rtl/wmul_ctrl.sv
module wmul_ctrl
  import wmul_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  elemSize,
  output ctrlStrobe_t strobe,
  output logic        outValid,
  output logic        illegalOp
);

  elemSize_e sizeCode;
  assign sizeCode = elemSize_e'(elemSize);

  assign strobe.load    = inValid;
  assign strobe.illegal = inValid && (sizeCode == SZ_BAD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      outValid  <= strobe.load;
      illegalOp <= strobe.illegal;
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !illegalOp));

  // R6
  bad_size_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && elemSize == 2'b11) |=> (illegalOp && outValid));

endmodule

// File: rtl/wmul_datapath.sv
module wmul_datapath
  import wmul_pkg::*;
#(
  parameter int VEC_BITS = 128
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [VEC_BITS-1:0]   opA,
  input  logic [VEC_BITS-1:0]   opB,
  input  logic [VEC_BITS-1:0]   oldDst,
  input  logic [1:0]            elemSize,
  input  logic                  isUnsigned,
  input  logic                  useTop,
  input  logic [VEC_BITS/8-1:0] byteMask,
  output logic [VEC_BITS-1:0]   result
);

  localparam int VEC_BYTES = VEC_BITS / 8;

  logic [VEC_BITS-1:0] prodBySize [NUM_SIZES];
  logic [VEC_BITS-1:0] prodSel;
  logic [VEC_BITS-1:0] merged;
  logic [VEC_BITS-1:0] resultQ;

  // one bank of lane multipliers per source size
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int ESZ   = MIN_ELEM_BITS << g;
    localparam int LANES = VEC_BITS / (2 * ESZ);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int LO = 2 * ESZ * l;
      logic [2*ESZ-1:0] laneProd;
      wmul_lane #(.ESZ(ESZ)) u_lane (
        .pairA   (opA[LO +: 2*ESZ]),
        .pairB   (opB[LO +: 2*ESZ]),
        .useTop  (useTop),
        .signExt (~isUnsigned),
        .prod    (laneProd)
      );
      assign prodBySize[g][LO +: 2*ESZ] = laneProd;
    end
  end

  always_comb begin
    unique case (elemSize_e'(elemSize))
      SZ_BYTE: prodSel = prodBySize[0];
      SZ_HALF: prodSel = prodBySize[1];
      SZ_WORD: prodSel = prodBySize[2];
      default: prodSel = '0;
    endcase
  end

  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_merge
    assign merged[8*b +: 8] = (byteMask[b] && !strobe.illegal)
                            ? prodSel[8*b +: 8] : oldDst[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN)            resultQ <= '0;
    else if (strobe.load) resultQ <= merged;
  end

  assign result = resultQ;

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(result));

  // R6
  bad_size_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.illegal |=> (result == $past(oldDst)));

  // R5
  mask_off_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && byteMask == '0) |=> (result == $past(oldDst)));

endmodule

// File: rtl/wmul_top.sv
module wmul_top
  import wmul_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [127:0] opA,
  input  logic [127:0] opB,
  input  logic [127:0] oldDst,
  input  logic [1:0]   elemSize,
  input  logic         isUnsigned,
  input  logic         useTop,
  input  logic [15:0]  byteMask,
  output logic         outValid,
  output logic [127:0] result,
  output logic         illegalOp
);

  ctrlStrobe_t strobe;

  wmul_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .elemSize  (elemSize),
    .strobe    (strobe),
    .outValid  (outValid),
    .illegalOp (illegalOp)
  );

  wmul_datapath #(.VEC_BITS(128)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opA        (opA),
    .opB        (opB),
    .oldDst     (oldDst),
    .elemSize   (elemSize),
    .isUnsigned (isUnsigned),
    .useTop     (useTop),
    .byteMask   (byteMask),
    .result     (result)
  );

endmodule

// File: tb/wmul_top_tb.sv
module wmul_top_tb;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] opA = '0, opB = '0, oldDst = '0;
  logic [1:0]   elemSize = 2'b00;
  logic         isUnsigned = 1'b0, useTop = 1'b0;
  logic [15:0]  byteMask = '0;
  logic         outValid, illegalOp;
  logic [127:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural expectation of the outputs
  logic         expValid = 1'b0, expIll = 1'b0;
  logic [127:0] expRes = '0;
  string        expReq = "R9";

  always #4 clk = ~clk;

  wmul_top u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .oldDst(oldDst), .elemSize(elemSize), .isUnsigned(isUnsigned),
    .useTop(useTop), .byteMask(byteMask), .outValid(outValid),
    .result(result), .illegalOp(illegalOp)
  );

  function automatic logic [127:0] refModel(
      logic [127:0] a, logic [127:0] b, logic [127:0] old,
      int size, bit uns, bit top, logic [15:0] mask);
    logic [127:0] res = old;
    if (size == 3) return old;
    begin
      int esz = 8 << size;
      int lanes = 128 / (2 * esz);
      int prodBytes = (2 * esz) / 8;
      longint unsigned emask = (64'd1 << esz) - 1;
      for (int i = 0; i < lanes; i++) begin
        int k = 2 * i + (top ? 1 : 0);
        longint unsigned ea = 64'(a >> (esz * k)) & emask;
        longint unsigned eb = 64'(b >> (esz * k)) & emask;
        logic [63:0] p;
        if (uns) p = ea * eb;
        else begin
          longint sa = longint'(ea);
          longint sb = longint'(eb);
          if (((ea >> (esz - 1)) & 1) != 0) sa = sa - (longint'(1) << esz);
          if (((eb >> (esz - 1)) & 1) != 0) sb = sb - (longint'(1) << esz);
          p = sa * sb;
        end
        for (int j = 0; j < prodBytes; j++) begin
          int bi = i * prodBytes + j;
          if (mask[bi]) res[8*bi +: 8] = p[8*j +: 8];
        end
      end
    end
    return res;
  endfunction

  task automatic checkOut();
    checks++;
    if (outValid !== expValid || illegalOp !== expIll || result !== expRes) begin
      failures++;
      $display("FAIL %s actual v=%b ill=%b res=%h expected v=%b ill=%b res=%h",
               expReq, outValid, illegalOp, result, expValid, expIll, expRes);
    end
  endtask

  // one clock: check current outputs, then drive the next input cycle
  task automatic step(bit v, logic [127:0] a, logic [127:0] b, logic [127:0] old,
                      int size, bit uns, bit top, logic [15:0] mask, string req);
    @(negedge clk);
    checkOut();
    inValid = v; opA = a; opB = b; oldDst = old;
    elemSize = 2'(size); isUnsigned = uns; useTop = top; byteMask = mask;
    expReq = req;
    if (v) begin
      expValid = 1'b1;
      expIll = (size == 3);
      expRes = refModel(a, b, old, size, uns, top, mask);
    end else begin
      expValid = 1'b0;
      expIll = 1'b0;
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] pat;
    // R9: reset state
    repeat (3) @(negedge clk);
    expReq = "R9";
    checkOut();
    @(negedge clk);
    rstN = 1'b1;

    pat = rnd128();
    // R3 signed extremes, all sizes
    step(1, {16{8'h80}}, {16{8'h80}}, pat, 0, 0, 0, 16'hFFFF, "R3");
    step(1, {8{16'h8000}}, {8{16'h8000}}, pat, 1, 0, 1, 16'hFFFF, "R3");
    step(1, {4{32'h80000000}}, {4{32'h80000000}}, pat, 2, 0, 0, 16'hFFFF, "R3");
    step(1, {16{8'hFF}}, {16{8'h01}}, pat, 0, 0, 1, 16'hFFFF, "R3");
    // R4 unsigned maxima
    step(1, {16{8'hFF}}, {16{8'hFF}}, pat, 0, 1, 0, 16'hFFFF, "R4");
    step(1, {8{16'hFFFF}}, {8{16'hFFFF}}, pat, 1, 1, 1, 16'hFFFF, "R4");
    step(1, {4{32'hFFFFFFFF}}, {4{32'hFFFFFFFF}}, pat, 2, 1, 0, 16'hFFFF, "R4");
    // R2 / R1: distinct even and odd elements, both variants, each size
    for (int s = 0; s < 3; s++) begin
      logic [127:0] ra = rnd128();
      logic [127:0] rb = rnd128();
      step(1, ra, rb, pat, s, 0, 0, 16'hFFFF, "R2");
      step(1, ra, rb, pat, s, 0, 1, 16'hFFFF, "R2");
      step(1, ra, rb, pat, s, 1, 1, 16'hFFFF, "R1");
    end
    // R5 zero mask and partial masks
    step(1, rnd128(), rnd128(), rnd128(), 1, 0, 0, 16'h0000, "R5");
    step(1, rnd128(), rnd128(), rnd128(), 2, 1, 1, 16'h0F0F, "R5");
    step(1, rnd128(), rnd128(), rnd128(), 0, 0, 1, 16'h8001, "R5");
    // R6 illegal size with full mask
    step(1, rnd128(), rnd128(), rnd128(), 3, 0, 0, 16'hFFFF, "R6");
    // R8 idle cycles with changing inputs
    step(0, rnd128(), rnd128(), rnd128(), 0, 1, 0, 16'hFFFF, "R8");
    step(0, rnd128(), rnd128(), rnd128(), 3, 0, 1, 16'hFFFF, "R8");
    // R7 back-to-back then random mix
    for (int n = 0; n < 1500; n++) begin
      bit v = ($urandom % 4) != 0;
      int s = ($urandom % 8 == 0) ? 3 : int'($urandom % 3);
      step(v, rnd128(), rnd128(), rnd128(), s, 1'($urandom), 1'($urandom),
           16'($urandom), "R7");
    end
    step(0, '0, '0, '0, 0, 0, 0, '0, "R8");
    step(0, '0, '0, '0, 0, 0, 0, '0, "R8");
    @(negedge clk);
    checkOut();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule